// File: doc/BRIEF.md
# Single-Step Shift and Rotate Arithmetic-Logic Unit

This block is the purely combinational arithmetic-logic unit of a small 32-bit load/store processor core. It takes two operands and a 4-bit operation selector and, within the same cycle, returns a result word and three flags: zero, carry/borrow and signed overflow. The datapath around it chooses the operands (register or immediate) and reads the zero flag to decide conditional branches on equality or inequality.

Eleven operation codes are defined: addition, subtraction, bitwise AND, bitwise OR, bitwise inversion of the first operand, three single-position shifts (arithmetic right, logical right, left), single-position rotations in both directions, and a pass-through of the first operand. All remaining selector values give a zero result. Shifts and rotations always move by exactly one bit position, so the second operand plays no part in them. The block has no clock and no reset; its outputs follow its inputs.

Top module: `alu11`

## Requirements
- R1: Code 0000 (add) gives result = (A + B) mod 2^32, and carry = 1 exactly when the unsigned sum exceeds 2^32 - 1.
- R2: Code 0001 (subtract) gives result = (A - B) mod 2^32, and carry = 1 exactly when A < B taken as unsigned numbers (a borrow).
- R3: For add and subtract, overflow = 1 exactly when the true signed (two's complement) result lies outside -2^31 .. 2^31 - 1.
- R4: Code 0010 gives A AND B; code 0011 gives A OR B.
- R5: Code 0100 gives the bitwise inverse of A; the value of B has no effect on any output.
- R6: Code 1000 shifts A right by one with bit 31 copied into the vacated bit 31; code 1001 shifts A right by one with a 0 entering bit 31.
- R7: Code 1010 shifts A left by one with a 0 entering bit 0.
- R8: Code 1100 rotates A left by one (old bit 31 enters bit 0); code 1101 rotates A right by one (old bit 0 enters bit 31).
- R9: Code 1110 returns A unchanged.
- R10: Codes 0101, 0110, 0111, 1011 and 1111 return a zero result.
- R11: The zero flag is 1 exactly when all 32 result bits are 0, for every code.
- R12: Carry and overflow are 0 for every code other than 0000 and 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation selector |
| a_i | input | 32 | First operand (the only operand of unary, shift and rotate codes) |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| carry_o | output | 1 | Carry out of add, borrow of subtract |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
Addition and subtraction are tried with operand pairs at the signed and unsigned limits (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, zero, equal operands), which separate carry from signed overflow and borrow from a plain negative result, and make a zero result flip the zero flag. The shift and rotate codes are driven with single-bit and edge-bit patterns such as 0x80000000 and 0x00000001, which show whether the end bit is dropped, zero-filled, sign-copied or wrapped, and so tell the five single-step moves apart. The inversion code is applied with two different second operands to show that B is not read, and every undefined code is swept to confirm a zero result with quiet flags. A run of pseudo-random operands across all sixteen codes is compared with an arithmetic model built on wide integers.

// File: rtl/alu11_pkg.sv
package alu11_pkg;

  localparam int DATA_W = 32;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_AND  = 4'b0010,
    OP_OR   = 4'b0011,
    OP_INV  = 4'b0100,
    OP_ASR  = 4'b1000,
    OP_LSR  = 4'b1001,
    OP_LSL  = 4'b1010,
    OP_ROL  = 4'b1100,
    OP_ROR  = 4'b1101,
    OP_PASS = 4'b1110
  } alu_op_e;

endpackage

// File: rtl/alu11_addsub.sv
module alu11_addsub #(
  parameter int W = alu11_pkg::DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o   = wide[W-1:0];
    carry_o = sub_i ? ~wide[W] : wide[W];
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end

  // Independent checks with sign-extended arithmetic one bit wider.
  logic signed [W:0] ext_res;

  always_comb begin
    if (sub_i) ext_res = $signed({a_i[W-1], a_i}) - $signed({b_i[W-1], b_i});
    else       ext_res = $signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i});
    // R3: overflow iff the wide signed result does not fit in W bits
    p_ovf_range_r3: assert (ovf_o == (ext_res != $signed({sum_o[W-1], sum_o})))
      else $error("overflow flag disagrees with wide signed result");
    // R2: borrow iff A < B unsigned
    p_borrow_r2: assert (!sub_i || (carry_o == (a_i < b_i)))
      else $error("borrow flag disagrees with unsigned compare");
  end

endmodule

// File: rtl/alu11_logic.sv
module alu11_logic #(
  parameter int W = alu11_pkg::DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] inv_o
);

  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    inv_o = ~a_i;
  end

  always_comb begin
    // R4: every bit set in the AND is also set in the OR
    p_and_in_or_r4: assert ((and_o & ~or_o) == '0)
      else $error("AND result not contained in OR result");
    // R5: inversion differs from A in every bit
    p_inv_all_r5: assert (&(inv_o ^ a_i))
      else $error("inversion leaves a bit of A unchanged");
  end

endmodule

// File: rtl/alu11_shift.sv
module alu11_shift #(
  parameter int W = alu11_pkg::DATA_W
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] asr_o,
  output logic [W-1:0] lsr_o,
  output logic [W-1:0] lsl_o,
  output logic [W-1:0] rol_o,
  output logic [W-1:0] ror_o
);

  localparam int MSB = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign asr_o[i] = a_i[MSB];
      assign lsr_o[i] = 1'b0;
      assign ror_o[i] = a_i[0];
    end else begin : g_mid
      assign asr_o[i] = a_i[i+1];
      assign lsr_o[i] = a_i[i+1];
      assign ror_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_low
      assign lsl_o[i] = 1'b0;
      assign rol_o[i] = a_i[MSB];
    end else begin : g_up
      assign lsl_o[i] = a_i[i-1];
      assign rol_o[i] = a_i[i-1];
    end
  end

  always_comb begin
    // R6: arithmetic right keeps the sign, logical right clears the top bit
    p_asr_sign_r6: assert (asr_o[MSB] == a_i[MSB] && lsr_o[MSB] == 1'b0)
      else $error("right shift fill bit wrong");
    // R7: left shift clears bit 0
    p_lsl_fill_r7: assert (lsl_o[0] == 1'b0)
      else $error("left shift fill bit wrong");
    // R8: rotations conserve the number of ones and wrap the end bit
    p_rot_wrap_r8: assert ($countones(rol_o) == $countones(a_i) &&
                           $countones(ror_o) == $countones(a_i) &&
                           rol_o[0] == a_i[MSB] && ror_o[MSB] == a_i[0])
      else $error("rotation lost or misplaced a bit");
  end

endmodule

// File: rtl/alu11.sv
module alu11
  import alu11_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            carry_o,
  output logic            ovf_o
);

  logic [W-1:0] sum_w, and_w, or_w, inv_w;
  logic [W-1:0] asr_w, lsr_w, lsl_w, rol_w, ror_w;
  logic         as_carry, as_ovf, is_arith, is_sub;

  assign is_sub   = (op_i == OP_SUB);
  assign is_arith = (op_i == OP_ADD) || is_sub;

  alu11_addsub #(.W(W)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (is_sub),
    .sum_o   (sum_w),
    .carry_o (as_carry),
    .ovf_o   (as_ovf)
  );

  alu11_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .or_o  (or_w),
    .inv_o (inv_w)
  );

  alu11_shift #(.W(W)) u_shift (
    .a_i   (a_i),
    .asr_o (asr_w),
    .lsr_o (lsr_w),
    .lsl_o (lsl_w),
    .rol_o (rol_w),
    .ror_o (ror_w)
  );

  always_comb begin
    case (op_i)
      OP_ADD,
      OP_SUB:  result_o = sum_w;
      OP_AND:  result_o = and_w;
      OP_OR:   result_o = or_w;
      OP_INV:  result_o = inv_w;
      OP_ASR:  result_o = asr_w;
      OP_LSR:  result_o = lsr_w;
      OP_LSL:  result_o = lsl_w;
      OP_ROL:  result_o = rol_w;
      OP_ROR:  result_o = ror_w;
      OP_PASS: result_o = a_i;
      default: result_o = '0;
    endcase
    carry_o = is_arith & as_carry;
    ovf_o   = is_arith & as_ovf;
    zero_o  = ~|result_o;
  end

  always_comb begin
    // R11: zero flag matches an all-zero result
    p_zero_flag_r11: assert (zero_o == ($countones(result_o) == 0))
      else $error("zero flag disagrees with result");
    // R12: flags stay low outside add and subtract
    p_flags_quiet_r12: assert (is_arith || (!carry_o && !ovf_o))
      else $error("flag raised by a non-arithmetic code");
    // R10: undefined codes give zero
    p_unused_zero_r10: assert (!(op_i == 4'b0101 || op_i == 4'b0110 || op_i == 4'b0111 ||
                                 op_i == 4'b1011 || op_i == 4'b1111) || zero_o)
      else $error("undefined code gave a non-zero result");
    // R9: pass-through returns A
    p_pass_a_r9: assert (op_i != OP_PASS || result_o == a_i)
      else $error("pass-through code altered A");
  end

endmodule

// File: tb/alu11_tb.sv
module alu11_tb;

  logic        clk;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [31:0] result;
  logic        zero, carry, ovf;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  alu11 u_dut (
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .result_o (result),
    .zero_o   (zero),
    .carry_o  (carry),
    .ovf_o    (ovf)
  );

  // Expected {ovf, carry, zero, result} from wide integer arithmetic.
  function automatic logic [34:0] model(input logic [3:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [32:0] w;
    longint      s;
    logic [31:0] r;
    logic        c, v;
    r = 32'd0; c = 1'b0; v = 1'b0; w = 33'd0; s = 0;
    case (f)
      4'b0000: begin
        w = {1'b0, x} + {1'b0, y};
        r = w[31:0]; c = w[32];
        s = longint'($signed(x)) + longint'($signed(y));
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'b0001: begin
        r = x - y; c = (x < y);
        s = longint'($signed(x)) - longint'($signed(y));
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'b0010: r = x & y;
      4'b0011: r = x | y;
      4'b0100: r = ~x;
      4'b1000: r = $unsigned($signed(x) >>> 1);
      4'b1001: r = x >> 1;
      4'b1010: r = x << 1;
      4'b1100: r = {x[30:0], x[31]};
      4'b1101: r = {x[0], x[31:1]};
      4'b1110: r = x;
      default: r = 32'd0;
    endcase
    return {v, c, (r == 32'd0), r};
  endfunction

  task automatic apply(input logic [3:0] f, input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    #1;
    op = f; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [34:0] exp;
    exp = model(f, x, y);
    apply(f, x, y);
    checks++;
    if ({ovf, carry, zero, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual res=%h z=%b c=%b v=%b expected res=%h z=%b c=%b v=%b",
               tag, f, x, y, result, zero, carry, ovf, exp[31:0], exp[32], exp[33], exp[34]);
    end
  endtask

  task automatic t_idle;
    // R11: all-zero inputs with add give a zero result and zero flag
    check("R11 idle", 4'b0000, 32'h0, 32'h0);
  endtask

  task automatic t_add;
    check("R1 add small",        4'b0000, 32'd5, 32'd7);
    check("R1 add carry wrap",   4'b0000, 32'hFFFF_FFFF, 32'd1);
    check("R3 add pos ovf",      4'b0000, 32'h7FFF_FFFF, 32'd1);
    check("R3 add neg ovf",      4'b0000, 32'h8000_0000, 32'h8000_0000);
    check("R1 add carry no ovf", 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_sub;
    check("R2 sub equal",        4'b0001, 32'h1234_5678, 32'h1234_5678);
    check("R2 sub borrow",       4'b0001, 32'd3, 32'd9);
    check("R3 sub min minus 1",  4'b0001, 32'h8000_0000, 32'd1);
    check("R3 sub max minus -1", 4'b0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    check("R2 sub no borrow",    4'b0001, 32'hFFFF_FFFF, 32'd1);
  endtask

  task automatic t_logic;
    check("R4 and", 4'b0010, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R4 or",  4'b0011, 32'hF0F0_F0F0, 32'h0F00_0F00);
    check("R4 and disjoint zero", 4'b0010, 32'hAAAA_AAAA, 32'h5555_5555);
  endtask

  task automatic t_inv;
    // R5: same A, two different B values, same outputs
    check("R5 not b0", 4'b0100, 32'h0F0F_0000, 32'h0000_0000);
    check("R5 not b1", 4'b0100, 32'h0F0F_0000, 32'hFFFF_FFFF);
    check("R5 not ones to zero", 4'b0100, 32'hFFFF_FFFF, 32'h1234_5678);
  endtask

  task automatic t_shifts;
    check("R6 asr neg",  4'b1000, 32'h8000_0000, 32'h0);
    check("R6 asr pos",  4'b1000, 32'h4000_0001, 32'h0);
    check("R6 lsr top",  4'b1001, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R6 lsr drop", 4'b1001, 32'h0000_0001, 32'h0);
    check("R7 lsl drop", 4'b1010, 32'h8000_0000, 32'h0);
    check("R7 lsl low",  4'b1010, 32'h0000_0001, 32'h7);
  endtask

  task automatic t_rotates;
    check("R8 rol wrap", 4'b1100, 32'h8000_0000, 32'h0);
    check("R8 rol mix",  4'b1100, 32'hC000_0003, 32'h0);
    check("R8 ror wrap", 4'b1101, 32'h0000_0001, 32'h0);
    check("R8 ror mix",  4'b1101, 32'h8000_0003, 32'h5);
  endtask

  task automatic t_pass;
    check("R9 pass", 4'b1110, 32'hDEAD_BEEF, 32'h1111_1111);
    check("R9 pass zero", 4'b1110, 32'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_unused;
    logic [3:0] codes [5] = '{4'b0101, 4'b0110, 4'b0111, 4'b1011, 4'b1111};
    for (int i = 0; i < 5; i++)
      check("R10 unused", codes[i], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_flags_quiet;
    // R12: operands that would carry/overflow as add, on other codes
    for (int f = 2; f < 16; f++)
      check("R12 flags quiet", 4'(f), 32'hFFFF_FFFF, 32'h8000_0001);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++)
      check("R11 random", 4'($urandom_range(0, 15)), $urandom, $urandom);
  endtask

  initial begin
    op = 4'b0000; a = 32'h0; b = 32'h0;
    repeat (2) @(posedge clk);
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_inv();
    t_shifts();
    t_rotates();
    t_pass();
    t_unused();
    t_flags_quiet();
    t_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule